// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-facing register front end of a 24-pin interrupt routing controller. Software sees only two 32-bit locations. One is a byte-wide select register. The other is a data window. The select value decides what the window reaches: a version word, a controller ID, an arbitration ID, or one 32-bit half of a 64-bit routing entry.

The block holds the routing table and drives every entry's fields to the delivery logic beside it. The delivery logic owns two status bits in each entry: the remote-IRR flag and the in-flight flag. It sets and clears them through strobe inputs, and software writes never change them.

Two pulses report write side effects:
- A service request goes out after a write leaves a level-triggered entry whose pin is requesting.
- A mask-change notice goes out when a low-half write flips an entry's mask bit.

Top module: `irq_route_regwin`

## Requirements
- R1: A write to the select location (`reg_addr`=0) keeps bits 7:0 of the data. Reading the select location returns that byte in bits 7:0 and zeros above it.
- R2: Select 0x01 reads the version word: pin count minus one in bits 23:16, `VER_ID` (default 0x11) in bits 7:0, zeros elsewhere. Writes to it change nothing.
- R3: Select 0x00 holds a 4-bit controller ID, written from and read back at bits 27:24, with all other read bits zero. Select 0x02 reads the same word and ignores writes.
- R4: Select 0x10+2n reaches bits 31:0 of entry n, and select 0x11+2n reaches bits 63:32. Data written to one half reads back unchanged except for the status bits, and other entries are not touched.
- R5: A select whose entry index ((sel-0x10)>>1) is at or beyond the pin count reads as 0xFFFFFFFF. A window write there changes no entry.
- R6: An entry write keeps the current remote-IRR bit (bit 14) and in-flight bit (bit 12), whatever the data holds in those positions. The exception is R7.
- R7: After any write to an entry whose trigger-mode bit (bit 15; 1 = level) is 0, that entry's remote-IRR bit is 0.
- R8: One cycle after a window write, `svc_req` pulses for one cycle with `svc_pin` set to the entry index. This happens only if the written entry is now level-triggered and its `pin_req` bit was set during the write.
- R9: After reset the select register is 0 and every entry reads 0x00010000 low and 0 high, so only the mask bit is set.
- R10: A low-half write that changes an entry's mask bit (bit 16) gives a one-cycle `mask_chg` pulse in the next cycle, with the pin index and the new mask value. A write that leaves the mask unchanged gives no pulse.
- R11: The field outputs show each entry as laid out in R4: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the addressed location |
| reg_addr | input | 1 | 0 = select register, 1 = data window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed location (combinational) |
| pin_req | input | NPINS | Current request level of each pin |
| rirr_set | input | NPINS | Delivery logic sets remote-IRR |
| rirr_clr | input | NPINS | Delivery logic clears remote-IRR |
| dstat_set | input | NPINS | Delivery logic sets the in-flight flag |
| dstat_clr | input | NPINS | Delivery logic clears the in-flight flag |
| ent_vector | output | NPINS*8 | Vector of each entry |
| ent_dlv_mode | output | NPINS*3 | Delivery mode of each entry |
| ent_dst_logical | output | NPINS | Destination mode of each entry |
| ent_dstat | output | NPINS | In-flight flag of each entry |
| ent_polarity | output | NPINS | Polarity of each entry |
| ent_rirr | output | NPINS | Remote-IRR of each entry |
| ent_level | output | NPINS | Trigger mode of each entry, 1 = level |
| ent_mask | output | NPINS | Mask of each entry |
| ent_dest | output | NPINS*8 | Destination of each entry |
| svc_req | output | 1 | One-cycle service request after an entry write |
| svc_pin | output | PW | Pin index for `svc_req` |
| mask_chg | output | 1 | One-cycle notice that a mask bit changed |
| mask_chg_pin | output | PW | Pin index for `mask_chg` |
| mask_chg_val | output | 1 | New mask value |

## Verification
The hardest case to reach is a software write that lands on an entry whose status bits were set by hardware rather than by software. Status preservation only means something when the write data carries the opposite value in those bit positions. The stimulus first pulses `rirr_set` and `dstat_set` for one pin. It then writes data that holds zeros in both positions and checks that both bits survive. Next it rewrites the same entry as edge-triggered and checks that only the remote-IRR bit drops. Service and mask pulses are checked in the exact cycle after each write, and again one cycle later to confirm they last only one cycle.

// File: rtl/irw_pkg.sv
package irw_pkg;

    // Field layout of one routing entry, bit 0 at the bottom.
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        level;
        logic        rirr;
        logic        polarity;
        logic        dstat;
        logic        dst_logical;
        logic [2:0]  dlv_mode;
        logic [7:0]  vector;
    } rte_t;

    typedef enum logic [2:0] {
        W_ID, W_VER, W_ARB, W_ENT, W_OOR, W_NONE
    } win_kind_e;

    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_RTE_BASE = 8'h10;

    localparam int unsigned BIT_DSTAT = 12;
    localparam int unsigned BIT_RIRR  = 14;
    localparam int unsigned BIT_LEVEL = 15;
    localparam int unsigned BIT_MASK  = 16;

    function automatic logic [7:0] rte_offset(input logic [7:0] sel);
        logic [7:0] diff;
        diff = sel - SEL_RTE_BASE;
        return diff >> 1;
    endfunction

    function automatic win_kind_e classify(input logic [7:0] sel,
                                           input int unsigned npins);
        if (sel == SEL_ID)              return W_ID;
        else if (sel == SEL_VER)        return W_VER;
        else if (sel == SEL_ARB)        return W_ARB;
        else if (sel < SEL_RTE_BASE)    return W_NONE;
        else if (32'(rte_offset(sel)) >= npins) return W_OOR;
        else                            return W_ENT;
    endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PW = $clog2(NPINS)
) (
    input  logic [7:0]    sel,
    output win_kind_e     kind,
    output logic [PW-1:0] idx,
    output logic          hi
);
    logic [7:0] off;

    always_comb begin
        off  = rte_offset(sel);
        kind = classify(sel, NPINS);
        idx  = off[PW-1:0];
        hi   = sel[0];
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dstat_set,
    input  logic        dstat_clr,
    output rte_t        ent
);
    rte_t ent_q;
    rte_t ent_d;
    logic rirr_hw;
    logic dstat_hw;

    always_comb begin
        rirr_hw  = (ent_q.rirr  | rirr_set)  & ~rirr_clr;
        dstat_hw = (ent_q.dstat | dstat_set) & ~dstat_clr;
        ent_d = ent_q;
        if (wr_lo) ent_d[31:0]  = wdata;
        if (wr_hi) ent_d[63:32] = wdata;
        // status bits belong to the delivery side
        ent_d.rirr  = rirr_hw;
        ent_d.dstat = dstat_hw;
        if ((wr_lo || wr_hi) && !ent_d.level)
            ent_d.rirr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q      <= '0;
            ent_q.mask <= 1'b1;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent = ent_q;

    p_keep_rirr_r6: assert property (@(posedge clk) disable iff (rst)
        ((wr_lo || wr_hi) && !rirr_set && !rirr_clr)
        |=> (ent_q.level ? (ent_q.rirr == $past(ent_q.rirr)) : !ent_q.rirr));

    p_keep_dstat_r6: assert property (@(posedge clk) disable iff (rst)
        ((wr_lo || wr_hi) && !dstat_set && !dstat_clr) |=> $stable(ent_q.dstat));

    p_edge_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_hi) |=> (ent_q.level || !ent_q.rirr));

    p_reset_mask_r9: assert property (@(posedge clk)
        $past(rst) |-> ent_q.mask);
endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
    import irw_pkg::*;
#(
    parameter int         NPINS  = 24,
    parameter logic [7:0] VER_ID = 8'h11
) (
    input  logic        win,
    input  logic [7:0]  sel,
    input  win_kind_e   kind,
    input  logic        hi,
    input  logic [3:0]  id,
    input  rte_t        cur,
    output logic [31:0] rdata
);
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [63:0] cur_bits;
    assign cur_bits = cur;

    always_comb begin
        if (!win) begin
            rdata = {24'h0, sel};
        end else begin
            unique case (kind)
                W_VER:        rdata = {8'h00, MAX_PIN, 8'h00, VER_ID};
                W_ID, W_ARB:  rdata = {4'h0, id, 24'h0};
                W_ENT:        rdata = hi ? cur_bits[63:32] : cur_bits[31:0];
                W_OOR:        rdata = '1;
                default:      rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int         NPINS  = 24,
    parameter logic [7:0] VER_ID = 8'h11,
    localparam int PW = $clog2(NPINS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NPINS-1:0]   pin_req,
    input  logic [NPINS-1:0]   rirr_set,
    input  logic [NPINS-1:0]   rirr_clr,
    input  logic [NPINS-1:0]   dstat_set,
    input  logic [NPINS-1:0]   dstat_clr,
    output logic [NPINS*8-1:0] ent_vector,
    output logic [NPINS*3-1:0] ent_dlv_mode,
    output logic [NPINS-1:0]   ent_dst_logical,
    output logic [NPINS-1:0]   ent_dstat,
    output logic [NPINS-1:0]   ent_polarity,
    output logic [NPINS-1:0]   ent_rirr,
    output logic [NPINS-1:0]   ent_level,
    output logic [NPINS-1:0]   ent_mask,
    output logic [NPINS*8-1:0] ent_dest,
    output logic               svc_req,
    output logic [PW-1:0]      svc_pin,
    output logic               mask_chg,
    output logic [PW-1:0]      mask_chg_pin,
    output logic               mask_chg_val
);
    logic [7:0]    sel_q;
    logic [3:0]    id_q;
    win_kind_e     kind;
    logic [PW-1:0] idx;
    logic          hi;
    rte_t          ents [NPINS];
    rte_t          cur;
    logic          cur_req;
    logic          win_wr;
    logic          ent_wr;
    logic          new_level;

    assign win_wr = reg_wr && reg_addr;
    assign ent_wr = win_wr && (kind == W_ENT);

    irw_decode #(.NPINS(NPINS)) u_dec (
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        logic hit;
        assign hit = ent_wr && (idx == PW'(i));

        irw_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .wr_lo     (hit && !hi),
            .wr_hi     (hit && hi),
            .wdata     (reg_wdata),
            .rirr_set  (rirr_set[i]),
            .rirr_clr  (rirr_clr[i]),
            .dstat_set (dstat_set[i]),
            .dstat_clr (dstat_clr[i]),
            .ent       (ents[i])
        );

        assign ent_vector[i*8 +: 8]   = ents[i].vector;
        assign ent_dlv_mode[i*3 +: 3] = ents[i].dlv_mode;
        assign ent_dst_logical[i]     = ents[i].dst_logical;
        assign ent_dstat[i]           = ents[i].dstat;
        assign ent_polarity[i]        = ents[i].polarity;
        assign ent_rirr[i]            = ents[i].rirr;
        assign ent_level[i]           = ents[i].level;
        assign ent_mask[i]            = ents[i].mask;
        assign ent_dest[i*8 +: 8]     = ents[i].dest;
    end

    // entry and request line picked by the current select
    always_comb begin
        cur     = '0;
        cur_req = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (idx == PW'(i)) begin
                cur     = ents[i];
                cur_req = pin_req[i];
            end
        end
        new_level = hi ? cur.level : reg_wdata[BIT_LEVEL];
    end

    irw_rdmux #(.NPINS(NPINS), .VER_ID(VER_ID)) u_rd (
        .win   (reg_addr),
        .sel   (sel_q),
        .kind  (kind),
        .hi    (hi),
        .id    (id_q),
        .cur   (cur),
        .rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q        <= '0;
            id_q         <= '0;
            svc_req      <= 1'b0;
            svc_pin      <= '0;
            mask_chg     <= 1'b0;
            mask_chg_pin <= '0;
            mask_chg_val <= 1'b0;
        end else begin
            if (reg_wr && !reg_addr)
                sel_q <= reg_wdata[7:0];
            if (win_wr && kind == W_ID)
                id_q <= reg_wdata[27:24];
            svc_req      <= ent_wr && new_level && cur_req;
            svc_pin      <= idx;
            mask_chg     <= ent_wr && !hi && (reg_wdata[BIT_MASK] != cur.mask);
            mask_chg_pin <= idx;
            mask_chg_val <= reg_wdata[BIT_MASK];
        end
    end

    p_svc_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> $past(reg_wr && reg_addr));

    p_svc_level_r8: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> ent_level[svc_pin]);

    p_mask_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        mask_chg |-> (ent_mask[mask_chg_pin] == mask_chg_val));

    p_sel_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> (sel_q == $past(reg_wdata[7:0])));
endmodule

// File: tb/irq_route_regwin_tb.sv
module irq_route_regwin_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 24;
    localparam int PW = $clog2(NPINS);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_wr = 1'b0;
    logic               reg_addr = 1'b0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NPINS-1:0]   pin_req = '0;
    logic [NPINS-1:0]   rirr_set = '0;
    logic [NPINS-1:0]   rirr_clr = '0;
    logic [NPINS-1:0]   dstat_set = '0;
    logic [NPINS-1:0]   dstat_clr = '0;
    logic [NPINS*8-1:0] ent_vector;
    logic [NPINS*3-1:0] ent_dlv_mode;
    logic [NPINS-1:0]   ent_dst_logical, ent_dstat, ent_polarity;
    logic [NPINS-1:0]   ent_rirr, ent_level, ent_mask;
    logic [NPINS*8-1:0] ent_dest;
    logic               svc_req, mask_chg, mask_chg_val;
    logic [PW-1:0]      svc_pin, mask_chg_pin;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_regwin #(.NPINS(NPINS)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_req(pin_req),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .dstat_set(dstat_set), .dstat_clr(dstat_clr),
        .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
        .ent_dst_logical(ent_dst_logical), .ent_dstat(ent_dstat),
        .ent_polarity(ent_polarity), .ent_rirr(ent_rirr),
        .ent_level(ent_level), .ent_mask(ent_mask), .ent_dest(ent_dest),
        .svc_req(svc_req), .svc_pin(svc_pin), .mask_chg(mask_chg),
        .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdw(input logic [7:0] s, output logic [31:0] d);
        wr(1'b0, {24'h0, s});
        rd(1'b1, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(1'b0, d);             chk("R9 select after reset", d, 32'h0);
        chk("R9 all masked", 32'(ent_mask), 32'(24'hFFFFFF));
        rdw(8'h10, d);           chk("R9 entry0 low", d, 32'h0001_0000);
        rdw(8'h11, d);           chk("R9 entry0 high", d, 32'h0);
    endtask

    task automatic t_select;
        logic [31:0] d;
        wr(1'b0, 32'hABCD_1234);
        rd(1'b0, d);             chk("R1 select low byte", d, 32'h0000_0034);
    endtask

    task automatic t_version;
        logic [31:0] d;
        rdw(8'h01, d);           chk("R2 version", d, 32'h0017_0011);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d);             chk("R2 version write ignored", d, 32'h0017_0011);
    endtask

    task automatic t_id;
        logic [31:0] d;
        wr(1'b0, 32'h00);
        wr(1'b1, 32'hF5A0_0000);
        rd(1'b1, d);             chk("R3 id readback", d, 32'h0500_0000);
        rdw(8'h02, d);           chk("R3 arb id mirrors", d, 32'h0500_0000);
        wr(1'b1, 32'h0F00_0000);
        rdw(8'h00, d);           chk("R3 arb write ignored", d, 32'h0500_0000);
    endtask

    task automatic t_entry;
        logic [31:0] d;
        wr(1'b0, 32'h1A);
        chk("R10 no pulse before write", 32'(mask_chg), 32'h0);
        wr(1'b1, 32'h0000_E9F3);
        chk("R10 mask change pulse", 32'(mask_chg), 32'h1);
        chk("R10 mask change pin", 32'(mask_chg_pin), 32'd5);
        chk("R10 mask change value", 32'(mask_chg_val), 32'h0);
        chk("R8 no service without request", 32'(svc_req), 32'h0);
        @(negedge clk);
        chk("R10 pulse lasts one cycle", 32'(mask_chg), 32'h0);
        wr(1'b0, 32'h1B);
        wr(1'b1, 32'h7E00_0000);
        rdw(8'h1A, d);           chk("R6 low half, status kept clear", d, 32'h0000_A9F3);
        rdw(8'h1B, d);           chk("R4 high half", d, 32'h7E00_0000);
        rdw(8'h18, d);           chk("R4 neighbour untouched", d, 32'h0001_0000);
        chk("R11 vector", 32'(ent_vector[5*8 +: 8]), 32'hF3);
        chk("R11 delivery mode", 32'(ent_dlv_mode[5*3 +: 3]), 32'h1);
        chk("R11 destination mode", 32'(ent_dst_logical[5]), 32'h1);
        chk("R11 polarity", 32'(ent_polarity[5]), 32'h1);
        chk("R11 level", 32'(ent_level[5]), 32'h1);
        chk("R11 mask", 32'(ent_mask[5]), 32'h0);
        chk("R11 destination", 32'(ent_dest[5*8 +: 8]), 32'h7E);
    endtask

    task automatic t_status;
        logic [31:0] d;
        @(negedge clk);
        rirr_set[5] = 1'b1; dstat_set[5] = 1'b1;
        @(negedge clk);
        rirr_set[5] = 1'b0; dstat_set[5] = 1'b0;
        rdw(8'h1A, d);           chk("R6 hw status visible", d, 32'h0000_F9F3);
        wr(1'b1, 32'h0000_89F3);
        chk("R10 unchanged mask no pulse", 32'(mask_chg), 32'h0);
        rd(1'b1, d);             chk("R6 status bits survive write", d, 32'h0000_D9F3);
        wr(1'b1, 32'h0000_09F3);
        rd(1'b1, d);             chk("R7 edge write clears remote IRR", d, 32'h0000_19F3);
        chk("R7 remote IRR port", 32'(ent_rirr[5]), 32'h0);
    endtask

    task automatic t_service;
        wr(1'b0, 32'h1E);
        pin_req[7] = 1'b1;
        wr(1'b1, 32'h0000_8040);
        chk("R8 service on level write", 32'(svc_req), 32'h1);
        chk("R8 service pin", 32'(svc_pin), 32'd7);
        @(negedge clk);
        chk("R8 service one cycle", 32'(svc_req), 32'h0);
        wr(1'b0, 32'h1F);
        wr(1'b1, 32'h0300_0000);
        chk("R8 service on high-half write", 32'(svc_req), 32'h1);
        wr(1'b0, 32'h1E);
        wr(1'b1, 32'h0000_0040);
        chk("R8 no service in edge mode", 32'(svc_req), 32'h0);
        pin_req[7] = 1'b0;
        wr(1'b1, 32'h0000_8040);
        chk("R8 no service without request", 32'(svc_req), 32'h0);
    endtask

    task automatic t_oor;
        logic [31:0] d;
        rdw(8'h40, d);           chk("R5 index 24 low reads ones", d, 32'hFFFF_FFFF);
        rdw(8'h41, d);           chk("R5 index 24 high reads ones", d, 32'hFFFF_FFFF);
        rdw(8'hFF, d);           chk("R5 top select reads ones", d, 32'hFFFF_FFFF);
        wr(1'b0, 32'h40);
        wr(1'b1, 32'h0000_0000);
        rdw(8'h3E, d);           chk("R5 ignored write, entry 23", d, 32'h0001_0000);
        rdw(8'h10, d);           chk("R5 ignored write, entry 0", d, 32'h0001_0000);
        wr(1'b0, 32'h3F);
        wr(1'b1, 32'h1200_0000);
        rd(1'b1, d);             chk("R4 last entry high half", d, 32'h1200_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_select;
        t_version;
        t_id;
        t_entry;
        t_status;
        t_service;
        t_oor;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule